// File: doc/BRIEF.md
# Ping-Pong SPI Flash Record Logger

This block accepts fixed-size sensor records and stores them in a serial, page-organised flash over a mode-0 SPI link. The flash holds two on-chip RAM page buffers. The logger streams record bytes into one buffer. When that buffer is full, it commits the buffer to a main-memory page with a program command that erases the page as part of the same operation. It then carries on filling the other buffer while the first one programs. The block generates every opcode, address and don't-care byte itself. It holds chip select low for the whole of each command.

Before each program command, the logger reads the device status until the ready bit is set. A page pointer steps through the whole array, so wear is spread across every page. A stop request finishes any held record, pads the open buffer with 0xFF, commits it, waits for ready and then reports completion. A record that arrives while the previous one is still waiting for room is discarded and counted.

Top module: `spi_flash_logger`

## Requirements
- R1: SPI runs in mode 0. The clock idles low and is low at every chip-select edge. Output data changes only while the clock is low, and input data is taken on the rising edge. Every byte is sent most significant bit first.
- R2: Chip select stays low from the opcode through every address and data byte of one command, and goes high between commands. Status reads are exactly 2 bytes, program commands exactly 4 bytes, and buffer writes at least 5 bytes.
- R3: Record bytes go to the device with a buffer-write command: opcode 0x84 for buffer A, 0x87 for buffer B. Then follow 3 address bytes, MSB first, carrying the byte offset in the low log2(PAGE_BYTES) bits with all higher bits zero. Byte 0 of a record is rec_data[8*REC_BYTES-1 -: 8], and the bytes fill consecutive offsets.
- R4: A full buffer is committed with opcode 0x83 (buffer A) or 0x86 (buffer B). The 3-byte address is page << log2(PAGE_BYTES), with the low bits zero. Each buffer fill is programmed exactly once.
- R5: Before every program command, and before done is raised, the block issues status reads (opcode 0xD7 followed by one read byte). Chip select goes high between reads, and the reads repeat until bit 7 of the returned byte is 1. No program command is issued while the device is busy.
- R6: The first buffer used is A, and programs alternate between buffers. The bytes that follow a program command go to the other buffer at once, while the program is still running.
- R7: The page pointer starts at 0 and advances by one per program command. It wraps to 0 after PAGE_CNT-1. Full is raised by the program of page PAGE_CNT-1 and stays high until reset.
- R8: A record that crosses a page boundary is split. Its leading bytes end the current buffer, and the rest start at offset 0 of the other buffer after the commit.
- R9: A record that arrives while the previously accepted record has not yet been fully written is dropped. ovf_cnt then increments, saturating at all ones.
- R10: A stop pulse lets any held record finish. It then pads the rest of a partly filled buffer with 0xFF, programs that buffer and polls until ready. After that, done goes high and stays high, and later records cause no SPI traffic and no count.
- R11: During and right after reset, spi_cs_n is 1, spi_sck is 0, and done, full and ovf_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | One-cycle record strobe |
| rec_data | input | 8*REC_BYTES | Record contents, first byte in the top bits |
| stop | input | 1 | Pulse to flush and finish logging |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | Flush complete, sticky |
| full | output | 1 | Page pointer has wrapped, sticky |
| ovf_cnt | output | OVF_W | Count of dropped records |

## Verification
Two functions can land on the same cycle. The first is the arrival of a record while the previous record still occupies the holding slot. The bench presents two records on consecutive cycles and checks that the second one never appears in flash and that the drop count rises by exactly one. The second is a stop request that arrives while a record is still being streamed and just after a page commit. The bench raises stop a few cycles after the record that crosses into the next buffer. It then checks three things: the record's last byte is stored ahead of the 0xFF padding, the status reads repeat while the earlier page is still programming, and done appears only once the flash model is idle.

// File: rtl/flog_pkg.sv
package flog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR,
      ST_POLL,
      ST_PROG,
      ST_DONE
   } flog_st_e;

   localparam logic [7:0] OP_WR_A  = 8'h84;
   localparam logic [7:0] OP_WR_B  = 8'h87;
   localparam logic [7:0] OP_PG_A  = 8'h83;
   localparam logic [7:0] OP_PG_B  = 8'h86;
   localparam logic [7:0] OP_STAT  = 8'hD7;
   localparam int         ADDR_W   = 24;
   localparam int         HDR_LAST = 3;

endpackage

// File: rtl/flog_spi_byte.sv
// One-byte mode-0 shifter; keeps only the first received bit (status ready flag).
module flog_spi_byte #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       done,
   output logic       rx_msb,
   output logic       sck,
   output logic       mosi
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         initial $fatal(1, "HALF_DIV must be at least 1");
      end
   endgenerate

   logic [7:0]    sh;
   logic [2:0]    bitn;
   logic [CW-1:0] cnt;
   logic          act;
   logic          sck_r;
   logic          done_r;
   logic          first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         bitn    <= '0;
         cnt     <= '0;
         act     <= 1'b0;
         sck_r   <= 1'b0;
         done_r  <= 1'b0;
         first_q <= 1'b0;
         rx_msb  <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (!act) begin
            if (start) begin
               act     <= 1'b1;
               sh      <= tx;
               cnt     <= '0;
               bitn    <= '0;
               first_q <= 1'b1;
            end
         end else if (cnt == CW'(HALF_DIV - 1)) begin
            cnt <= '0;
            if (!sck_r) begin
               sck_r <= 1'b1;
               if (first_q) begin
                  rx_msb  <= miso;
                  first_q <= 1'b0;
               end
            end else begin
               sck_r <= 1'b0;
               sh    <= {sh[6:0], 1'b0};
               bitn  <= bitn + 3'd1;
               if (bitn == 3'd7) begin
                  act    <= 1'b0;
                  done_r <= 1'b1;
               end
            end
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   assign done = done_r;
   assign sck  = sck_r;
   assign mosi = sh[7];

   AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_r && $past(sck_r)) |-> $stable(mosi)); // R1
   AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && !$past(act)) |-> !sck_r); // R1

endmodule

// File: rtl/flog_page_ptr.sv
module flog_page_ptr #(
   parameter int PAGE_CNT = 4096
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        adv,
   output logic [$clog2(PAGE_CNT)-1:0] page,
   output logic                        full
);
   localparam int  PG_W  = $clog2(PAGE_CNT);
   localparam bit  POW2  = (PAGE_CNT == (1 << PG_W));
   localparam logic [PG_W-1:0] LAST = PG_W'(PAGE_CNT - 1);

   generate
      if (PAGE_CNT < 2) begin : g_bad_cnt
         initial $fatal(1, "PAGE_CNT must be at least 2");
      end
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   page <= '0;
            else if (adv) page <= page + PG_W'(1);
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   page <= '0;
            else if (adv) page <= (page == LAST) ? '0 : page + PG_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      full <= 1'b0;
      else if (adv && (page == LAST))  full <= 1'b1;
   end

   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> full); // R7
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(page)); // R7

endmodule

// File: rtl/flog_ovf_ctr.sv
module flog_ovf_ctr #(
   parameter int OVF_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [OVF_W-1:0] cnt
);
   generate
      if (OVF_W < 1) begin : g_bad_w
         initial $fatal(1, "OVF_W must be at least 1");
      end
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (inc && cnt != '1)   cnt <= cnt + OVF_W'(1);
         end
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == '1) |=> (cnt == '1)); // R9
      end else begin : g_roll
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + OVF_W'(1);
         end
      end
   endgenerate

   AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt)); // R9

endmodule

// File: rtl/spi_flash_logger.sv
module spi_flash_logger
   import flog_pkg::*;
#(
   parameter int PAGE_BYTES   = 512,
   parameter int PAGE_CNT     = 4096,
   parameter int REC_BYTES    = 5,
   parameter int SCK_HALF     = 2,
   parameter int OVF_W        = 8,
   parameter bit OVF_SATURATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rec_valid,
   input  logic [8*REC_BYTES-1:0] rec_data,
   input  logic                   stop,
   output logic                   spi_sck,
   output logic                   spi_cs_n,
   output logic                   spi_mosi,
   input  logic                   spi_miso,
   output logic                   done,
   output logic                   full,
   output logic [OVF_W-1:0]       ovf_cnt
);
   localparam int BY_W = $clog2(PAGE_BYTES);
   localparam int PG_W = $clog2(PAGE_CNT);
   localparam int RB_W = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;
   localparam logic [BY_W-1:0] OFF_LAST = BY_W'(PAGE_BYTES - 1);
   localparam logic [RB_W-1:0] REC_LAST = RB_W'(REC_BYTES - 1);

   generate
      if (PAGE_BYTES != (1 << BY_W) || PAGE_BYTES < 2) begin : g_bad_page
         initial $fatal(1, "PAGE_BYTES must be a power of two");
      end
      if (BY_W + PG_W > ADDR_W) begin : g_bad_addr
         initial $fatal(1, "page and offset exceed the address width");
      end
      if (REC_BYTES < 1) begin : g_bad_rec
         initial $fatal(1, "REC_BYTES must be at least 1");
      end
   endgenerate

   flog_st_e               st, after_poll;
   logic                   cs_n_q, in_fl, pad, buf_sel, hold_vld, stop_req;
   logic [8*REC_BYTES-1:0] hold;
   logic [2:0]             bidx;
   logic [BY_W-1:0]        off;
   logic [RB_W-1:0]        rbyte;
   logic                   start, sdone, rdy_bit, adv, hold_clr;
   logic [7:0]             tx, rec_byte;
   logic [PG_W-1:0]        page;
   logic [ADDR_W-1:0]      wr_addr, pg_addr;
   logic                   last_data, rec_last, data_ph;

   function automatic logic [7:0] abyte(input logic [ADDR_W-1:0] a, input logic [2:0] i);
      case (i)
         3'd1:    abyte = a[23:16];
         3'd2:    abyte = a[15:8];
         default: abyte = a[7:0];
      endcase
   endfunction

   assign wr_addr   = ADDR_W'(off);
   assign pg_addr   = ADDR_W'(page) << BY_W;
   assign last_data = (off == OFF_LAST);
   assign rec_last  = (rbyte == REC_LAST);
   assign data_ph   = (bidx > 3'(HDR_LAST));
   assign start     = (st == ST_WR || st == ST_POLL || st == ST_PROG) && !in_fl;
   assign rec_byte  = hold[8*(REC_BYTES - 1 - int'(rbyte)) +: 8];
   assign adv       = (st == ST_PROG) && sdone && (bidx == 3'(HDR_LAST));
   assign hold_clr  = (st == ST_WR) && sdone && data_ph && !pad && rec_last;

   always_comb begin
      tx = 8'h00;
      case (st)
         ST_WR:   tx = (bidx == 3'd0) ? (buf_sel ? OP_WR_B : OP_WR_A) :
                       (!data_ph)     ? abyte(wr_addr, bidx) :
                       (pad ? 8'hFF : rec_byte);
         ST_POLL: tx = (bidx == 3'd0) ? OP_STAT : 8'h00;
         ST_PROG: tx = (bidx == 3'd0) ? (buf_sel ? OP_PG_B : OP_PG_A) : abyte(pg_addr, bidx);
         default: tx = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  after_poll <= ST_IDLE;
         cs_n_q <= 1'b1; in_fl <= 1'b0; pad <= 1'b0; buf_sel <= 1'b0;
         hold_vld <= 1'b0; stop_req <= 1'b0; hold <= '0;
         bidx <= '0; off <= '0; rbyte <= '0;
      end else begin
         if (stop) stop_req <= 1'b1;
         if (start) begin
            in_fl  <= 1'b1;
            cs_n_q <= 1'b0;
         end
         if (rec_valid && !hold_vld && st != ST_DONE) begin
            hold_vld <= 1'b1;
            hold     <= rec_data;
         end else if (hold_clr) begin
            hold_vld <= 1'b0;
         end
         case (st)
            ST_IDLE: begin
               bidx <= '0;
               if (hold_vld) begin
                  st  <= ST_WR;
                  pad <= 1'b0;
               end else if (stop_req) begin
                  if (off != '0) begin
                     st  <= ST_WR;
                     pad <= 1'b1;
                  end else begin
                     st         <= ST_POLL;
                     after_poll <= ST_DONE;
                  end
               end
            end
            ST_WR: if (sdone) begin
               in_fl <= 1'b0;
               if (!data_ph) begin
                  bidx <= bidx + 3'd1;
               end else begin
                  off <= off + BY_W'(1);
                  if (!pad) rbyte <= rec_last ? '0 : rbyte + RB_W'(1);
                  if (last_data || (!pad && rec_last)) begin
                     cs_n_q <= 1'b1;
                     if (last_data) begin
                        st         <= ST_POLL;
                        after_poll <= ST_PROG;
                        bidx       <= '0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
            end
            ST_POLL: if (sdone) begin
               in_fl <= 1'b0;
               if (bidx == 3'd0) begin
                  bidx <= 3'd1;
               end else begin
                  cs_n_q <= 1'b1;
                  bidx   <= '0;
                  if (rdy_bit) st <= after_poll;
               end
            end
            ST_PROG: if (sdone) begin
               in_fl <= 1'b0;
               if (bidx != 3'(HDR_LAST)) begin
                  bidx <= bidx + 3'd1;
               end else begin
                  cs_n_q  <= 1'b1;
                  buf_sel <= ~buf_sel;
                  bidx    <= '0;
                  if (pad) begin
                     st         <= ST_POLL;
                     after_poll <= ST_DONE;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   flog_spi_byte #(.HALF_DIV(SCK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tx(tx), .miso(spi_miso),
      .done(sdone), .rx_msb(rdy_bit), .sck(spi_sck), .mosi(spi_mosi));

   flog_page_ptr #(.PAGE_CNT(PAGE_CNT)) u_page (
      .clk(clk), .rst_n(rst_n), .adv(adv), .page(page), .full(full));

   flog_ovf_ctr #(.OVF_W(OVF_W), .SATURATE(OVF_SATURATE)) u_ovf (
      .clk(clk), .rst_n(rst_n), .inc(rec_valid && hold_vld && st != ST_DONE), .cnt(ovf_cnt));

   assign spi_cs_n = cs_n_q;
   assign done     = (st == ST_DONE);

   AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n); // R2
   AST_CS_EDGE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(spi_cs_n) || $rose(spi_cs_n)) |-> !spi_sck); // R1
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && spi_cs_n)); // R10
   AST_OFF_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (off == '0)); // R8

endmodule

// File: tb/spi_flash_logger_tb_top.sv
`timescale 1ns/1ps
module spi_flash_logger_tb_top;
   localparam int PB   = 16;
   localparam int BYW  = 4;
   localparam int PG   = 4;
   localparam int RB   = 5;
   localparam int BUSY = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rec_valid = 1'b0;
   logic [8*RB-1:0] rec_data = '0;
   logic stop = 1'b0;
   logic spi_sck, spi_cs_n, spi_mosi;
   logic spi_miso = 1'b0;
   logic done, full;
   logic [3:0] ovf_cnt;

   always #2.5 clk = ~clk;

   spi_flash_logger #(.PAGE_BYTES(PB), .PAGE_CNT(PG), .REC_BYTES(RB),
      .SCK_HALF(2), .OVF_W(4), .OVF_SATURATE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
      .stop(stop), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .done(done), .full(full), .ovf_cnt(ovf_cnt));

   // ---------------- flash model ----------------
   int cyc = 0;
   int busy_until = 0;
   always @(posedge clk) cyc <= cyc + 1;
   function automatic bit busy_now();
      return cyc < busy_until;
   endfunction

   logic [7:0] xb [32];
   logic [7:0] sr = '0;
   int nb = 0, bitc = 0;
   logic [7:0] mem [PG*PB];
   logic [7:0] bufm [2][PB];
   int progcnt [PG];
   int mode_err = 0, proto_err = 0, addr_err = 0, alt_err = 0, prog_busy_err = 0;
   int busy_polls = 0, xact_cnt = 0, nprog = 0;
   bit overlap_seen = 0;
   bit last_wr_buf = 0, last_pg_buf = 0;

   initial begin
      for (int i = 0; i < PG*PB; i++) mem[i] = 8'h00;
      for (int i = 0; i < PG; i++) progcnt[i] = 0;
   end

   always @(posedge spi_sck or negedge spi_cs_n) begin
      if (!spi_sck) begin
         nb = 0; bitc = 0;
      end else if (!spi_cs_n) begin
         sr = {sr[6:0], spi_mosi};
         bitc = bitc + 1;
         if (bitc % 8 == 0) begin
            if (nb < 32) xb[nb] = sr;
            nb = nb + 1;
         end
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_cs_n && bitc >= 8 && xb[0] == 8'hD7)
         spi_miso <= (bitc % 8 == 0) ? !busy_now() : 1'b0;
      else
         spi_miso <= 1'b0;
   end

   always @(posedge spi_cs_n) begin : m_end
      logic [7:0] op;
      logic [23:0] addr;
      bit bsel;
      int o, pg;
      if (spi_sck) mode_err++;
      if (nb > 0) begin
         xact_cnt++;
         op = xb[0];
         addr = {xb[1], xb[2], xb[3]};
         bsel = (op == 8'h87 || op == 8'h86);
         case (op)
            8'h84, 8'h87: begin
               if (nb < 5) proto_err++;
               if ((addr >> BYW) != 0) addr_err++;
               if (busy_now() && nprog > 0 && bsel == last_pg_buf) alt_err++;
               if (busy_now()) overlap_seen = 1;
               for (int i = 4; i < nb && i < 32; i++) begin
                  o = int'(addr[BYW-1:0]) + i - 4;
                  if (o < PB) bufm[bsel][o] = xb[i]; else proto_err++;
               end
               last_wr_buf = bsel;
            end
            8'h83, 8'h86: begin
               if (nb != 4) proto_err++;
               if (addr[BYW-1:0] != 0) addr_err++;
               pg = int'(addr >> BYW);
               if (pg >= PG) begin addr_err++; pg = 0; end
               if (busy_now()) prog_busy_err++;
               if (bsel != last_wr_buf) alt_err++;
               if (nprog == 0 && bsel != 1'b0) alt_err++;
               if (nprog > 0 && bsel == last_pg_buf) alt_err++;
               for (int i = 0; i < PB; i++) mem[pg*PB + i] = bufm[bsel][i];
               progcnt[pg]++;
               busy_until = cyc + BUSY;
               last_pg_buf = bsel;
               nprog++;
            end
            8'hD7: begin
               if (nb != 2) proto_err++;
               if (busy_now()) busy_polls++;
            end
            default: proto_err++;
         endcase
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_fail = 0;
   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   logic [7:0] expb [80];
   int ne = 0;
   task automatic push_rec(input logic [8*RB-1:0] r);
      for (int k = 0; k < RB; k++) begin
         expb[ne] = r[8*RB-1-8*k -: 8];
         ne++;
      end
   endtask

   task automatic send(input logic [8*RB-1:0] r);
      @(negedge clk); rec_valid = 1'b1; rec_data = r;
      @(negedge clk); rec_valid = 1'b0;
   endtask

   // {record, gap cycles, expected full after the gap}
   localparam logic [56:0] TBL [12] = '{
      {40'h11_12_13_14_15, 16'd3000, 1'b0},
      {40'h21_22_23_24_25, 16'd3000, 1'b0},
      {40'h31_32_33_34_35, 16'd3000, 1'b0},
      {40'h41_42_43_44_45, 16'd3000, 1'b0},
      {40'h51_52_53_54_55, 16'd3000, 1'b0},
      {40'h61_62_63_64_65, 16'd3000, 1'b0},
      {40'h71_72_73_74_75, 16'd3000, 1'b0},
      {40'h81_82_83_84_85, 16'd3000, 1'b0},
      {40'h91_92_93_94_95, 16'd3000, 1'b0},
      {40'hA1_A2_A3_A4_A5, 16'd3000, 1'b0},
      {40'hB1_B2_B3_B4_B5, 16'd3000, 1'b0},
      {40'hC1_C2_C3_C4_C5, 16'd8,    1'b0}
   };

   logic [7:0] snap0 [PB];

   task automatic run_all();
      int bad, xs;
      repeat (6) @(negedge clk);
      chk("R11 cs_n in reset", int'(spi_cs_n), 1);
      chk("R11 sck in reset", int'(spi_sck), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R11 done after reset", int'(done), 0);
      chk("R11 full after reset", int'(full), 0);
      chk("R11 ovf after reset", int'(ovf_cnt), 0);

      for (int e = 0; e < 12; e++) begin
         send(TBL[e][56:17]);
         push_rec(TBL[e][56:17]);
         repeat (int'(TBL[e][16:1])) @(negedge clk);
         chk($sformatf("R7 full after entry %0d", e), int'(full), int'(TBL[e][0]));
         if (e == 7) begin
            for (int i = 0; i < PB; i++) snap0[i] = mem[i];
            // R9: two records on consecutive cycles, second one must be dropped
            @(negedge clk); rec_valid = 1'b1; rec_data = 40'hD1_D2_D3_D4_D5;
            @(negedge clk); rec_data = 40'hEE_EE_EE_EE_EE;
            @(negedge clk); rec_valid = 1'b0;
            push_rec(40'hD1_D2_D3_D4_D5);
            repeat (3000) @(negedge clk);
            chk("R9 ovf_cnt after burst", int'(ovf_cnt), 1);
         end
      end

      // R10: stop while the crossing record is still being written
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      while (!done) @(negedge clk);
      chk("R5 done only when flash idle", int'(busy_now()), 0);
      chk("R5 repeated busy polls seen", int'(busy_polls > 0), 1);
      chk("R7 full after wrap", int'(full), 1);

      bad = 0;
      for (int i = 0; i < PB; i++) if (snap0[i] != expb[i]) bad++;
      chk("R3 first fill of page 0", bad, 0);
      chk("R8 split record continues on page 1", int'(mem[PB]), int'(expb[16]));
      for (int p = 1; p < PG; p++) begin
         bad = 0;
         for (int i = 0; i < PB; i++) if (mem[p*PB + i] != expb[p*PB + i]) bad++;
         chk($sformatf("R3 page %0d contents", p), bad, 0);
      end
      chk("R10 last record byte before pad", int'(mem[0]), int'(expb[64]));
      bad = 0;
      for (int i = 1; i < PB; i++) if (mem[i] != 8'hFF) bad++;
      chk("R10 pad bytes 0xFF", bad, 0);
      chk("R4 page 0 programmed twice", progcnt[0], 2);
      for (int p = 1; p < PG; p++)
         chk($sformatf("R4 page %0d programmed once", p), progcnt[p], 1);
      chk("R1 sck low at cs edges", mode_err, 0);
      chk("R2 command lengths", proto_err, 0);
      chk("R3 don't-care address bits zero", addr_err, 0);
      chk("R5 no program while busy", prog_busy_err, 0);
      chk("R6 buffer alternation", alt_err, 0);
      chk("R6 fill overlaps programming", int'(overlap_seen), 1);

      xs = xact_cnt;
      send(40'h5A_5A_5A_5A_5A);
      repeat (1500) @(negedge clk);
      chk("R10 no traffic after done", xact_cnt, xs);
      chk("R10 ovf unchanged after done", int'(ovf_cnt), 1);
      chk("R10 done stays high", int'(done), 1);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule